// File: doc/BRIEF.md
# Lockable Watchdog Timer

This block is a register-mapped watchdog. A 32-bit down-counter runs from a software-loaded reload value once the interrupt enable has been set. The first time the counter reaches zero it raises a timeout status bit, which drives the interrupt line. If software has not serviced that timeout, then the next time the counter reaches zero the block issues a one-clock reset request. Software services the watchdog by writing any value to the clear register. That write drops the status and restarts the count from the reload value.

A key register protects the configuration from stray writes. Writing the unlock key opens the registers, and writing any other value closes them again. The test-enable bit stays writable while locked. With test mode on, the reset request is held back and recorded as a cause bit, so a watchdog expiry can be tested without resetting the system. A stall option freezes the counter while a debug-halt input is high. A separate output flags the interrupt as non-maskable when software has selected that.

The bus is a single-cycle write port. Read data is registered and appears one clock after the address.

Top module: `wdt_lockable`

## Requirements
- R1: After reset, the reload register (offset 0x000) and the count register (offset 0x004) read 0xFFFFFFFF. Control (0x008), raw status (0x010), masked status (0x014), test (0x418), cause (0x41C) and key (0xC00) read 0. The outputs irq, nmi_flag and reset_req are 0.
- R2: An accepted write to offset 0x000 stores the reload value and loads the count with it at the same clock edge. While control bit 0 is set, the count then falls by one every clock.
- R3: When the count is 0 on an active clock, raw status bit 0 is set and the count reloads from the reload register. Writing 0 to offset 0x000 sets raw status bit 0 at that same write.
- R4: An accepted write of any data to offset 0x00C clears raw status bit 0 and cause bit 1, and reloads the count from the reload register.
- R5: Control bit 0 is the interrupt enable. Writing 0 to it never clears it; only reset does. Control bit 1 enables the reset request, and control bit 2 selects the non-maskable type. Both can be rewritten freely.
- R6: Masked status bit 0 and the irq output equal raw status bit 0 AND the interrupt enable. The nmi_flag output equals control bit 2.
- R7: If the count reaches 0 while raw status is already set and control bit 1 is set, reset_req goes high for exactly one clock. reset_req is never high on two consecutive clocks.
- R8: While test bit 0 is set, the reset request of R7 is suppressed and cause bit 1 is set instead. Cause bit 0 always mirrors raw status bit 0.
- R9: While test bit 8 is set and dbg_halt is high, the count holds its value. With test bit 8 clear, dbg_halt has no effect.
- R10: Writing 0x1ACCE551 to offset 0xC00 unlocks the block, and writing any other value locks it. The key register reads 1 when locked and 0 when unlocked. While locked, all writes are ignored except those to the key register and to test bit 0.
- R11: Reads return data one clock after the address is presented. Reserved bits, the clear register and unmapped offsets read 0, and reads have no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | 12 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data for the previous cycle's addr |
| dbg_halt | input | 1 | Debug halt indication |
| irq | output | 1 | Watchdog interrupt |
| nmi_flag | output | 1 | Interrupt is to be treated as non-maskable |
| reset_req | output | 1 | One-clock system reset request |

## Verification
Most faults inside this block reach the ports only after a full countdown, so the checks are placed to catch them at that point. A count that steps wrongly shows up in the next count read. A status bit that sets or clears wrongly moves irq on the following clock. A reset decision made without the first timeout, or made through test mode, shows as a reset_req pulse at the wrong time, or as a missing pulse, within two reload periods. A lock that does not hold shows up in the next readback of the register that was written.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned OFF_W = 12;
  localparam logic [OFF_W-1:0] OFF_RELOAD = 12'h000;
  localparam logic [OFF_W-1:0] OFF_COUNT  = 12'h004;
  localparam logic [OFF_W-1:0] OFF_CTRL   = 12'h008;
  localparam logic [OFF_W-1:0] OFF_CLEAR  = 12'h00C;
  localparam logic [OFF_W-1:0] OFF_RAW    = 12'h010;
  localparam logic [OFF_W-1:0] OFF_MASKED = 12'h014;
  localparam logic [OFF_W-1:0] OFF_TEST   = 12'h418;
  localparam logic [OFF_W-1:0] OFF_CAUSE  = 12'h41C;
  localparam logic [OFF_W-1:0] OFF_KEY    = 12'h C00;
  localparam logic [31:0] UNLOCK_KEY = 32'h1ACCE551;

  typedef struct packed {
    logic nmi_sel;
    logic rst_en;
    logic int_en;
  } ctrl_t;
endpackage

// File: rtl/wdt_regfile.sv
module wdt_regfile
  import wdt_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] reload_q,
  output ctrl_t             ctrl_q,
  output logic              stall_q,
  output logic              test_q,
  output logic              locked_q,
  output logic              load_pulse,
  output logic              clear_pulse
);
  logic wr_ok;
  logic hit_reload, hit_ctrl, hit_clear, hit_test, hit_key;

  assign hit_reload = (addr == ADDR_W'(OFF_RELOAD));
  assign hit_ctrl   = (addr == ADDR_W'(OFF_CTRL));
  assign hit_clear  = (addr == ADDR_W'(OFF_CLEAR));
  assign hit_test   = (addr == ADDR_W'(OFF_TEST));
  assign hit_key    = (addr == ADDR_W'(OFF_KEY));

  assign wr_ok       = wr_en && !locked_q;
  assign load_pulse  = wr_ok && hit_reload;
  assign clear_pulse = wr_ok && hit_clear;

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '1;
      ctrl_q   <= '0;
      stall_q  <= 1'b0;
      test_q   <= 1'b0;
      locked_q <= 1'b0;
    end else begin
      if (load_pulse) reload_q <= wdata;
      if (wr_ok && hit_ctrl) begin
        ctrl_q.int_en  <= ctrl_q.int_en | wdata[0];
        ctrl_q.rst_en  <= wdata[1];
        ctrl_q.nmi_sel <= wdata[2];
      end
      if (wr_en && hit_test) begin
        test_q <= wdata[0];
        if (!locked_q) stall_q <= wdata[8];
      end
      if (wr_en && hit_key) locked_q <= (wdata != DATA_W'(UNLOCK_KEY));
    end
  end
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              int_en,
  input  logic              rst_en,
  input  logic              test_q,
  input  logic              stall_q,
  input  logic              dbg_halt,
  input  logic              load_pulse,
  input  logic              clear_pulse,
  input  logic [DATA_W-1:0] load_data,
  input  logic [DATA_W-1:0] reload_q,
  output logic [DATA_W-1:0] count_q,
  output logic              raw_q,
  output logic              cause_rst_q,
  output logic              reset_req_q
);
  logic run;
  logic at_zero;

  assign run     = int_en && !(stall_q && dbg_halt);
  assign at_zero = (count_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q     <= '1;
      raw_q       <= 1'b0;
      cause_rst_q <= 1'b0;
      reset_req_q <= 1'b0;
    end else begin
      reset_req_q <= 1'b0;
      if (load_pulse) begin
        count_q <= load_data;
        if (load_data == '0) raw_q <= 1'b1;
      end else if (clear_pulse) begin
        count_q     <= reload_q;
        raw_q       <= 1'b0;
        cause_rst_q <= 1'b0;
      end else if (run) begin
        if (at_zero) begin
          count_q <= reload_q;
          raw_q   <= 1'b1;
          if (raw_q && rst_en) begin
            if (test_q) cause_rst_q <= 1'b1;
            else        reset_req_q <= !reset_req_q;
          end
        end else begin
          count_q <= count_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wdt_readmux.sv
module wdt_readmux
  import wdt_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] reload_q,
  input  logic [DATA_W-1:0] count_q,
  input  ctrl_t             ctrl_q,
  input  logic              raw_q,
  input  logic              stall_q,
  input  logic              test_q,
  input  logic              cause_rst_q,
  input  logic              locked_q,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] sel;

  always_comb begin
    sel = '0;
    case (addr)
      ADDR_W'(OFF_RELOAD): sel = reload_q;
      ADDR_W'(OFF_COUNT):  sel = count_q;
      ADDR_W'(OFF_CTRL):   sel = DATA_W'(ctrl_q);
      ADDR_W'(OFF_RAW):    sel = DATA_W'(raw_q);
      ADDR_W'(OFF_MASKED): sel = DATA_W'(raw_q & ctrl_q.int_en);
      ADDR_W'(OFF_TEST):   sel = DATA_W'({stall_q, 7'b0, test_q});
      ADDR_W'(OFF_CAUSE):  sel = DATA_W'({cause_rst_q, raw_q});
      ADDR_W'(OFF_KEY):    sel = DATA_W'(locked_q);
      default:             sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= sel;
  end
endmodule

// File: rtl/wdt_lockable.sv
module wdt_lockable
  import wdt_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              dbg_halt,
  output logic              irq,
  output logic              nmi_flag,
  output logic              reset_req
);
  logic [DATA_W-1:0] reload_q;
  logic [DATA_W-1:0] count_q;
  ctrl_t             ctrl_q;
  logic              stall_q, test_q, locked_q;
  logic              load_pulse, clear_pulse;
  logic              raw_q, cause_rst_q;

  wdt_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .reload_q(reload_q), .ctrl_q(ctrl_q), .stall_q(stall_q),
    .test_q(test_q), .locked_q(locked_q),
    .load_pulse(load_pulse), .clear_pulse(clear_pulse)
  );

  wdt_core #(.DATA_W(DATA_W)) u_core (
    .clk(clk), .rst(rst), .int_en(ctrl_q.int_en), .rst_en(ctrl_q.rst_en),
    .test_q(test_q), .stall_q(stall_q), .dbg_halt(dbg_halt),
    .load_pulse(load_pulse), .clear_pulse(clear_pulse),
    .load_data(wdata), .reload_q(reload_q),
    .count_q(count_q), .raw_q(raw_q), .cause_rst_q(cause_rst_q),
    .reset_req_q(reset_req)
  );

  wdt_readmux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst(rst), .addr(addr), .reload_q(reload_q),
    .count_q(count_q), .ctrl_q(ctrl_q), .raw_q(raw_q),
    .stall_q(stall_q), .test_q(test_q), .cause_rst_q(cause_rst_q),
    .locked_q(locked_q), .rdata(rdata)
  );

  assign irq      = raw_q & ctrl_q.int_en;
  assign nmi_flag = ctrl_q.nmi_sel;
endmodule

// File: rtl/wdt_checks.sv
module wdt_checks #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              dbg_halt,
  input logic              int_en,
  input logic              rst_en,
  input logic              stall_q,
  input logic              test_q,
  input logic              locked_q,
  input logic              raw_q,
  input logic [DATA_W-1:0] count_q,
  input logic [DATA_W-1:0] reload_q,
  input logic              reset_req
);
  logic running;
  assign running = int_en && !(stall_q && dbg_halt) && !wr_en;

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (running && count_q > 1) |=> (count_q == $past(count_q) - 1)) else $error("AST_COUNT_STEP"); // R2
  AST_RAW_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
    (running && count_q == '0) |=> raw_q) else $error("AST_RAW_ON_WRAP"); // R3
  AST_EN_STICKY: assert property (@(posedge clk) disable iff (rst)
    !$fell(int_en)) else $error("AST_EN_STICKY"); // R5
  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    reset_req |=> !reset_req) else $error("AST_RST_ONE_CYCLE"); // R7
  AST_RST_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> $past(rst_en)) else $error("AST_RST_NEEDS_EN"); // R7
  AST_TEST_BLOCKS_RST: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> !$past(test_q)) else $error("AST_TEST_BLOCKS_RST"); // R8
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (stall_q && dbg_halt && !wr_en) |=> $stable(count_q)) else $error("AST_HALT_FREEZE"); // R9
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    locked_q |=> $stable(reload_q)) else $error("AST_LOCK_HOLDS"); // R10
endmodule

bind wdt_lockable wdt_checks #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .dbg_halt(dbg_halt),
  .int_en(ctrl_q.int_en), .rst_en(ctrl_q.rst_en), .stall_q(stall_q),
  .test_q(test_q), .locked_q(locked_q), .raw_q(raw_q),
  .count_q(count_q), .reload_q(reload_q), .reset_req(reset_req)
);

// File: tb/tb_wdt_lockable.sv
module tb_wdt_lockable;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        dbg_halt = 1'b0;
  logic        irq, nmi_flag, reset_req;

  int checks = 0;
  int failures = 0;
  int pulses = 0;
  bit wide = 1'b0;
  logic prev_rr = 1'b0;

  localparam logic [11:0] A_RELOAD = 12'h000, A_COUNT = 12'h004, A_CTRL = 12'h008,
                          A_CLEAR = 12'h00C, A_RAW = 12'h010, A_MASK = 12'h014,
                          A_TEST = 12'h418, A_CAUSE = 12'h41C, A_KEY = 12'hC00;

  always #10 clk = ~clk;

  wdt_lockable dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .dbg_halt(dbg_halt), .irq(irq), .nmi_flag(nmi_flag),
    .reset_req(reset_req)
  );

  always @(posedge clk) begin
    if (rst) begin
      prev_rr <= 1'b0;
    end else begin
      prev_rr <= reset_req;
      if (reset_req) pulses <= pulses + 1;
      if (reset_req && prev_rr) wide <= 1'b1;
    end
  end

  function automatic logic [31:0] exp_count(input logic [31:0] ld, input int waited);
    return ld - 32'(waited);
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog timeout actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v, c1, c2, c3;
    int p0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(A_RELOAD, v); check(v, 32'hFFFFFFFF, "R1 reload");
    rd(A_COUNT, v);  check(v, 32'hFFFFFFFF, "R1 count");
    rd(A_CTRL, v);   check(v, 0, "R1 ctrl");
    rd(A_RAW, v);    check(v, 0, "R1 raw");
    rd(A_TEST, v);   check(v, 0, "R1 test");
    rd(A_KEY, v);    check(v, 0, "R1 key");
    check({29'b0, irq, nmi_flag, reset_req}, 0, "R1 outputs");

    // R11 unmapped and clear read as zero
    rd(12'h100, v); check(v, 0, "R11 unmapped");
    rd(A_CLEAR, v); check(v, 0, "R11 clear reads 0");

    // R5 enable and stickiness, nmi select
    wr(A_CTRL, 32'h5);
    check({31'b0, nmi_flag}, 1, "R6 nmi_flag");
    rd(A_CTRL, v); check(v, 5, "R5 ctrl fields");
    wr(A_CTRL, 32'h0);
    rd(A_CTRL, v); check(v, 1, "R5 enable sticky");
    check({31'b0, nmi_flag}, 0, "R6 nmi_flag cleared");

    // R2 randomized reload/countdown
    for (int i = 0; i < 20; i++) begin
      logic [31:0] ld;
      int k;
      ld = 32'(100 + ($urandom % 900));
      k = int'($urandom % 50);
      wr(A_RELOAD, ld);
      repeat (k) @(negedge clk);
      rd(A_COUNT, v);
      check(v, exp_count(ld, k), "R2 countdown");
    end

    // R3 timeout sets raw, R6 irq/masked, R8 cause mirror
    wr(A_CLEAR, 0);
    wr(A_RELOAD, 32'd5);
    repeat (10) @(negedge clk);
    rd(A_RAW, v);  check(v, 1, "R3 raw after wrap");
    rd(A_MASK, v); check(v, 1, "R6 masked");
    check({31'b0, irq}, 1, "R6 irq high");
    rd(A_CAUSE, v); check(v, 1, "R8 cause mirrors raw");

    // R4 clear
    wr(A_CLEAR, 32'hDEAD);
    rd(A_COUNT, v); check(v, 5, "R4 count reloaded");
    rd(A_RAW, v);   check(v, 0, "R4 raw cleared");
    check({31'b0, irq}, 0, "R6 irq low");

    // R3 zero load
    wr(A_RELOAD, 0);
    rd(A_RAW, v); check(v, 1, "R3 zero load");
    wr(A_RELOAD, 32'd1000);
    wr(A_CLEAR, 0);

    // R7 reset request on second timeout
    wr(A_CTRL, 32'h3);
    wr(A_RELOAD, 32'd6);
    wr(A_CLEAR, 0);
    p0 = pulses;
    repeat (10) @(negedge clk);
    check(32'(pulses), 32'(p0), "R7 no reset after first timeout");
    repeat (6) @(negedge clk);
    check(32'(pulses), 32'(p0 + 1), "R7 reset after second timeout");
    check({31'b0, wide}, 0, "R7 pulse width");
    wr(A_CTRL, 32'h1);
    wr(A_RELOAD, 32'd1000);
    wr(A_CLEAR, 0);

    // R8 test mode diverts reset
    wr(A_TEST, 32'h1);
    wr(A_CTRL, 32'h3);
    wr(A_RELOAD, 32'd6);
    wr(A_CLEAR, 0);
    p0 = pulses;
    repeat (18) @(negedge clk);
    check(32'(pulses), 32'(p0), "R8 reset suppressed");
    rd(A_CAUSE, v); check(v, 3, "R8 cause bit set");
    wr(A_CTRL, 32'h1);
    wr(A_RELOAD, 32'd1000);
    wr(A_CLEAR, 0);
    rd(A_CAUSE, v); check(v, 0, "R4 clear drops cause");
    wr(A_TEST, 32'h0);

    // R9 debug halt
    wr(A_TEST, 32'h100);
    dbg_halt = 1'b1;
    rd(A_COUNT, c1);
    repeat (10) @(negedge clk);
    rd(A_COUNT, c2);
    check(c2, c1, "R9 frozen");
    dbg_halt = 1'b0;
    repeat (10) @(negedge clk);
    rd(A_COUNT, c3);
    check({31'b0, (c3 < c2)}, 1, "R9 resumes");
    wr(A_TEST, 32'h0);
    dbg_halt = 1'b1;
    rd(A_COUNT, c1);
    repeat (5) @(negedge clk);
    rd(A_COUNT, c2);
    check(c2, c1 - 6, "R9 halt ignored without stall");
    dbg_halt = 1'b0;

    // R10 lock
    wr(A_KEY, 32'h0);
    rd(A_KEY, v); check(v, 1, "R10 locked reads 1");
    wr(A_RELOAD, 32'd77);
    rd(A_RELOAD, v); check(v, 1000, "R10 reload protected");
    wr(A_TEST, 32'h101);
    rd(A_TEST, v); check(v, 1, "R10 test bit exempt, stall locked");
    wr(A_CTRL, 32'h4);
    rd(A_CTRL, v); check(v, 1, "R10 ctrl protected");
    wr(A_KEY, 32'h1ACCE551);
    rd(A_KEY, v); check(v, 0, "R10 unlocked reads 0");
    wr(A_TEST, 32'h0);
    wr(A_RELOAD, 32'd77);
    rd(A_RELOAD, v); check(v, 77, "R10 write after unlock");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule